// File: doc/BRIEF.md
# Serial-Chain Interrupt Acknowledge Arbiter

The block collects interrupt requests from a row of device stages and merges them into one interrupt line to the processor. When the processor acknowledges, the acknowledge enters the first stage and travels along the row. A stage that holds a request takes the acknowledge and stops it. A stage with no request lets it pass on to the next stage. The stage that takes the acknowledge puts its own fixed vector on a shared output, which is flagged valid for one cycle. Priority therefore comes only from a stage's place in the row. Stage 0 sits next to the processor and wins over every stage behind it.

Each stage stores its request until that request is served, so a one-cycle request pulse is enough. The rising edge of the acknowledge input counts as one acknowledge. The stage count, the vector width and the rule for vector values are parameters. The pass-through output of the last stage is brought out so that further chains can be attached behind this one.

Top module: `intr_chain_arb`

## Requirements
- R1: `intr_o` is high in every cycle after the clock edge at which at least one stage holds a pending request, and low when no stage holds one.
- R2: A single-cycle pulse on `req_i[i]` leaves stage i pending until that stage is granted.
- R3: Only a rising edge of `ack_i` is an acknowledge. Holding `ack_i` high for several cycles yields one vector, not several.
- R4: On an acknowledge, the pending stage with the lowest index wins. All higher-index stages are blocked.
- R5: The winner of an acknowledge sampled at clock edge k is shown after edge k for exactly one cycle. During that cycle `vec_valid_o` is 1, `grant_o` is one-hot with bit i set, and `vec_o` equals VEC_BASE + i*VEC_STRIDE, truncated to VEC_W bits.
- R6: The granted stage drops its pending request at the acknowledge edge. Every other pending stage keeps its request.
- R7: An acknowledge that finds no stage pending produces no vector: `vec_valid_o` stays 0 and `grant_o` stays 0. In the cycle before that edge, `chain_po_o` is 1. In all other cycles `chain_po_o` is 0.
- R8: Whenever `vec_valid_o` is 0, `vec_o` is all zeros.
- R9: A new request on the same stage in the same cycle as its grant leaves that stage pending.
- R10: While `rst_ni` is low, nothing is pending and `intr_o`, `vec_valid_o`, `vec_o` and `grant_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_STAGES | Request pulse per stage; bit 0 has the highest priority |
| ack_i | input | 1 | Processor acknowledge; its rising edge starts one grant |
| intr_o | output | 1 | Combined interrupt line to the processor |
| vec_o | output | VEC_W | Vector of the granted stage; zero when not valid |
| vec_valid_o | output | 1 | `vec_o` holds a vector in this cycle |
| grant_o | output | NUM_STAGES | One-hot flag of the stage whose vector is shown |
| chain_po_o | output | 1 | Pass-through output of the last stage, for attaching further chains |

## Verification
The assertions assume that `ack_i` changes only between clock edges. They also assume that each high phase of `ack_i` is preceded by at least one low cycle, which is what makes a vector flag one cycle wide with a gap after it. A new request in the grant cycle may keep a stage pending, so the pending-clear check excludes stages whose request input was high at that edge. The bench drives all inputs on the falling edge. It produces acknowledges by random toggling of `ack_i`, which always keeps a low cycle between edges. Directed sequences cover a held acknowledge, an empty acknowledge, a full row and a re-request during the grant.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;

  // fixed vector of a stage, computed from base and stride
  function automatic int unsigned stage_vec(int unsigned base, int unsigned stride, int unsigned idx);
    return base + idx * stride;
  endfunction

endpackage

// File: rtl/intr_chain_ack_edge.sv
module intr_chain_ack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic ack_pulse_o
);

  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_i;
  end

  assign ack_pulse_o = ack_i & ~ack_q;

endmodule

// File: rtl/intr_chain_stage.sv
module intr_chain_stage #(
  parameter int unsigned VEC_W     = 8,
  parameter logic [VEC_W-1:0] STAGE_VEC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             pi_i,
  output logic             po_o,
  output logic             pend_o,
  output logic             sel_o,
  output logic [VEC_W-1:0] vec_o
);

  logic pend_q;

  assign sel_o  = pi_i & pend_q;
  assign po_o   = pi_i & ~pend_q;
  assign pend_o = pend_q;
  assign vec_o  = sel_o ? STAGE_VEC : '0;

  // a request in the grant cycle wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= req_i | (pend_q & ~sel_o);
  end

endmodule

// File: rtl/intr_chain_vec_bus.sv
module intr_chain_vec_bus #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned VEC_W      = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_STAGES-1:0]                 sel_i,
  input  logic [NUM_STAGES-1:0][VEC_W-1:0]      vec_i,
  output logic [VEC_W-1:0]                      vec_o,
  output logic                                  vec_valid_o,
  output logic [NUM_STAGES-1:0]                 grant_o
);

  logic [VEC_W-1:0] vec_d;

  always_comb begin
    vec_d = '0;
    for (int i = 0; i < NUM_STAGES; i++) vec_d = vec_d | vec_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
      grant_o     <= '0;
    end else begin
      vec_o       <= vec_d;
      vec_valid_o <= |sel_i;
      grant_o     <= sel_i;
    end
  end

endmodule

// File: rtl/intr_chain_arb.sv
module intr_chain_arb #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned VEC_BASE   = 64,
  parameter int unsigned VEC_STRIDE = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STAGES-1:0] req_i,
  input  logic                  ack_i,
  output logic                  intr_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  vec_valid_o,
  output logic [NUM_STAGES-1:0] grant_o,
  output logic                  chain_po_o
);

  localparam int unsigned LAST = NUM_STAGES - 1;

  logic                             ack_pulse;
  logic [NUM_STAGES:0]              pi_chain;
  logic [NUM_STAGES-1:0]            pend_w;
  logic [NUM_STAGES-1:0]            sel_w;
  logic [NUM_STAGES-1:0][VEC_W-1:0] gated_vec;

  intr_chain_ack_edge u_ack_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .ack_pulse_o (ack_pulse)
  );

  assign pi_chain[0] = ack_pulse;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    localparam logic [VEC_W-1:0] STAGE_VEC =
      VEC_W'(intr_chain_pkg::stage_vec(VEC_BASE, VEC_STRIDE, g));
    intr_chain_stage #(
      .VEC_W     (VEC_W),
      .STAGE_VEC (STAGE_VEC)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[g]),
      .pi_i   (pi_chain[g]),
      .po_o   (pi_chain[g+1]),
      .pend_o (pend_w[g]),
      .sel_o  (sel_w[g]),
      .vec_o  (gated_vec[g])
    );
  end

  intr_chain_vec_bus #(
    .NUM_STAGES (NUM_STAGES),
    .VEC_W      (VEC_W)
  ) u_vec_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_w),
    .vec_i       (gated_vec),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .grant_o     (grant_o)
  );

  assign intr_o     = |pend_w;
  assign chain_po_o = pi_chain[LAST+1];

endmodule

// File: rtl/intr_chain_arb_chk.sv
module intr_chain_arb_chk #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned VEC_W      = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_STAGES-1:0] req_i,
  input logic                  intr_o,
  input logic [VEC_W-1:0]      vec_o,
  input logic                  vec_valid_o,
  input logic [NUM_STAGES-1:0] grant_o,
  input logic                  chain_po_o,
  input logic [NUM_STAGES-1:0] pend_i
);

  assert_grant_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_valid_has_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o == (grant_o != '0));

  assert_single_vector_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  assert_vector_needs_intr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(intr_o));

  assert_empty_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_po_o |-> !intr_o);

  assert_idle_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> vec_o == '0);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_clr
    assert_grant_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[g] && !$past(req_i[g])) |-> !pend_i[g]);
  end

endmodule

bind intr_chain_arb intr_chain_arb_chk #(
  .NUM_STAGES (NUM_STAGES),
  .VEC_W      (VEC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .intr_o      (intr_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .grant_o     (grant_o),
  .chain_po_o  (chain_po_o),
  .pend_i      (pend_w)
);

// File: tb/intr_chain_arb_tb_top.sv
module intr_chain_arb_tb_top;

  localparam int unsigned N      = 4;
  localparam int unsigned VW     = 8;
  localparam int unsigned BASE   = 64;
  localparam int unsigned STRIDE = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic          ack_i = 1'b0;
  logic          intr_o, vec_valid_o, chain_po_o;
  logic [VW-1:0] vec_o;
  logic [N-1:0]  grant_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // model state
  logic [N-1:0]  m_pend = '0;
  logic          m_ack_prev = 1'b0;
  logic [N-1:0]  m_grant = '0;
  logic          m_valid = 1'b0;
  logic [VW-1:0] m_vec = '0;

  always #2 clk_i = ~clk_i;

  intr_chain_arb #(
    .NUM_STAGES (N),
    .VEC_W      (VW),
    .VEC_BASE   (BASE),
    .VEC_STRIDE (STRIDE)
  ) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .ack_i       (ack_i),
    .intr_o      (intr_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .grant_o     (grant_o),
    .chain_po_o  (chain_po_o)
  );

  function automatic logic [VW-1:0] vec_of(int i);
    return VW'(BASE + i * STRIDE);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk(tag, "intr_o", 32'(intr_o), 32'(|m_pend));
    chk(tag, "vec_valid_o", 32'(vec_valid_o), 32'(m_valid));
    chk(tag, "vec_o", 32'(vec_o), 32'(m_vec));
    chk(tag, "grant_o", 32'(grant_o), 32'(m_grant));
  endtask

  // drive on falling edge, check pass-through before the rising edge, outputs after it
  task automatic step(logic [N-1:0] req, logic ack, string tag);
    logic pulse;
    req_i = req;
    ack_i = ack;
    #1;
    pulse = ack & ~m_ack_prev;
    chk(tag, "chain_po_o", 32'(chain_po_o), 32'(pulse && (m_pend == '0)));
    @(posedge clk_i);
    m_grant = '0;
    if (pulse) begin
      for (int i = 0; i < N; i++)
        if (m_pend[i] && m_grant == '0) m_grant[i] = 1'b1;
    end
    m_valid = (m_grant != '0);
    m_vec = '0;
    for (int i = 0; i < N; i++) if (m_grant[i]) m_vec = vec_of(i);
    m_pend = req | (m_pend & ~m_grant);
    m_ack_prev = ack;
    @(negedge clk_i);
    chk_outs(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk_outs("R10");
    rst_ni = 1'b1;

    // R7 empty acknowledge passes the whole row
    step('0, 1'b1, "R7");
    step('0, 1'b0, "R7");

    // R1 R2 single pulse on stage 2, then served; R5 vector and R6 clear
    step(4'b0100, 1'b0, "R1");
    step('0, 1'b0, "R2");
    step('0, 1'b1, "R5");
    step('0, 1'b0, "R6");

    // R4 full row; R3 held acknowledge gives one vector
    step(4'b1111, 1'b0, "R4");
    step('0, 1'b1, "R4");
    step('0, 1'b1, "R3");
    step('0, 1'b1, "R3");
    step('0, 1'b0, "R6");
    step('0, 1'b1, "R4");
    step('0, 1'b0, "R4");
    step('0, 1'b1, "R4");
    step('0, 1'b0, "R4");
    step('0, 1'b1, "R5");
    step('0, 1'b0, "R1");

    // R9 re-request during grant keeps the stage pending
    step(4'b0010, 1'b0, "R9");
    step(4'b0010, 1'b1, "R9");
    step('0, 1'b0, "R9");
    step('0, 1'b1, "R9");
    step('0, 1'b0, "R8");

    // random mix; R8 idle bus checked through vec_o compare
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r;
      r = (($urandom % 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      step(r, (($urandom % 3) == 0), "R4");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule